// File: doc/BRIEF.md
# Clocked Serial Receiver with Overrun

This block receives bytes over a synchronous serial link on which it is the clock master. Software turns reception on through a control register. From then on the block drives a serial clock output and shifts one data bit in on each rising edge of that clock, least significant bit first. Each finished byte is parked in a receive buffer that the CPU reads through a small register port.

A buffer-full flag tells software that a byte is waiting. Software reads the byte and then writes 0 to that flag to accept the next one. If a byte completes while the buffer is still unread, the new byte is thrown away and an overrun flag is raised. An error flag and an error interrupt line can be raised with it. A receive interrupt line reports a full buffer.

Turning reception off does not cut a byte in half. The byte in flight is finished and delivered, and the clock then parks high. The serial clock rate is set by a clock-enable tick supplied from outside: every tick moves the serial clock by half a period.

Top module: `clk_ser_rx`

## Requirements
- R1: Reception runs only while control bit 0 (receive enable) is 1 and control bit 1 (auto mode) is 0. When not receiving, `serClk` stays high and no bit is taken in.
- R2: `serClk` changes level only in cycles where `tickEn` is 1. After reception starts, the first tick drives it low, and each following tick inverts it, so one serial clock period spans exactly two ticks.
- R3: `serData` is sampled when `serClk` rises, least significant bit first. After the eighth sample the assembled byte appears at register select 2, and status bit 0 (buffer full) becomes 1.
- R4: `rxIrq` is 1 exactly while status bit 0, control bit 2 (receive interrupt enable) and control bit 4 (global interrupt enable) are all 1.
- R5: A write to register select 1 clears each status bit whose written bit is 0 and leaves alone each status bit whose written bit is 1. A buffer load in the same cycle as a clear of bit 0 leaves bit 0 set.
- R6: When a byte completes while status bit 0 is 1, status bit 1 (overrun) becomes 1 and the buffer keeps its old value.
- R7: When an overrun occurs while control bit 3 (error interrupt enable) and control bit 4 are both 1, status bit 2 (error flag) becomes 1, and `errIrq` is 1 while status bit 2, control bit 3 and control bit 4 are all 1. Status bit 2 is cleared by writing 0 to status bit 1 or status bit 2, or by writing 0 to control bit 3 or control bit 4.
- R8: Writing 0 to receive enable in the middle of a byte lets that byte finish and be delivered. After that, `serClk` stays high and no further bit is taken in.
- R9: After reset, the control, status and buffer registers read 0, `serClk` is 1, and both interrupt lines are 0.
- R10: The bit counter is at zero whenever reception starts. After a stop and a restart, the first bit sampled becomes bit 0 of the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Half-period tick for the serial clock |
| serData | input | 1 | Serial data from the sender |
| serClk | output | 1 | Serial clock driven to the sender, idles high |
| regSel | input | 2 | Register select: 0 control, 1 status, 2 receive buffer |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data of the selected register (combinational) |
| rxIrq | output | 1 | Receive-full interrupt request (level) |
| errIrq | output | 1 | Overrun error interrupt request (level) |

## Verification
The hardest situations to reach from the ports depend on timing.

- A byte must finish while the buffer is still unread, and the error enables must be in a chosen state at that moment. The bench reaches this by leaving the buffer uncleared across whole bytes and changing the enables only in the gap after a byte completes. It picks these actions at random for each byte.
- Reception must be disabled while a byte is partway through. The bench counts `serClk` rising edges and writes the disable three bits into a byte. It then checks that the remaining bits still arrive, that the byte lands, and that the clock then parks high.
- The sender model drives one new bit on every falling edge of `serClk`. Expected bytes therefore follow from the count of rising edges alone.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef struct packed {
    logic start;   // reception begins: clear the bit counter
    logic sample;  // rising serial edge: shift one bit in
    logic load;    // byte complete and buffer free: copy to buffer
  } rxStrobe_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam int CB_RXEN   = 0;
  localparam int CB_AUTO   = 1;
  localparam int CB_RXIE   = 2;
  localparam int CB_ERRIE  = 3;
  localparam int CB_GLOBIE = 4;
  localparam int CTRL_BITS = 5;

  localparam int SB_FULL = 0;
  localparam int SB_OVR  = 1;
  localparam int SB_ERR  = 2;

endpackage

// File: rtl/rxs_datapath.sv
module rxs_datapath
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic              serData,
  output logic              lastBit,
  output logic              firstBit,
  output logic [DATA_W-1:0] rxBuf
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] shNext;

  assign shNext   = {serData, shReg[DATA_W-1:1]};
  assign lastBit  = (bitCnt == LAST_IDX);
  assign firstBit = (bitCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      shReg  <= '0;
      rxBuf  <= '0;
    end else begin
      if (strb.start) begin
        bitCnt <= '0;
      end else if (strb.sample) begin
        shReg  <= shNext;
        bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
      end
      if (strb.load) rxBuf <= shNext;
    end
  end

  // R6: buffer only moves on a load strobe
  a_r6_buffer_held: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(rxBuf));

  // R10: a start leaves the counter at zero
  a_r10_start_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> firstBit);

endmodule

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      goRx,
  input  logic      bufFull,
  input  logic      lastBit,
  input  logic      firstBit,
  output rxStrobe_t strb,
  output logic      loadEvt,
  output logic      overrunEvt,
  output logic      serClk
);
  logic running;
  logic serClkQ;
  logic riseNow;
  logic byteEnd;
  logic stopNow;

  assign serClk  = serClkQ;
  assign riseNow = running & tickEn & ~serClkQ;
  assign byteEnd = riseNow & lastBit;
  // stop only at a byte boundary with the clock parked high
  assign stopNow = running & serClkQ & firstBit & ~goRx;

  always_comb begin
    strb        = '0;
    strb.start  = ~running & goRx;
    strb.sample = riseNow;
    strb.load   = byteEnd & ~bufFull;
  end

  assign loadEvt    = strb.load;
  assign overrunEvt = byteEnd & bufFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      serClkQ <= 1'b1;
    end else if (!running) begin
      serClkQ <= 1'b1;
      if (goRx) running <= 1'b1;
    end else if (stopNow) begin
      running <= 1'b0;
    end else if (tickEn) begin
      serClkQ <= ~serClkQ;
    end
  end

  // R1: clock parked high while not receiving
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> serClkQ);

  // R2: serial clock moves only on a tick
  a_r2_tick_only: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(serClkQ));

  // R8: reception ends only between bytes
  a_r8_stop_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> ($past(firstBit) && $past(serClkQ)));

endmodule

// File: rtl/rxs_regs.sv
module rxs_regs
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] rxBuf,
  input  logic              loadEvt,
  input  logic              overrunEvt,
  output logic              goRx,
  output logic              bufFull,
  output logic              rxIrq,
  output logic              errIrq
);
  logic rxEn, autoMode, rxIe, errIe, globIe;
  logic overrun, errFlag;
  logic ctrlWr, statWr;
  logic errClr, errSet;
  logic unusedWrBits;

  assign ctrlWr = wrEn & (regSel == SEL_CTRL);
  assign statWr = wrEn & (regSel == SEL_STAT);
  assign errClr = (statWr & (~wrData[SB_OVR] | ~wrData[SB_ERR]))
                | (ctrlWr & (~wrData[CB_ERRIE] | ~wrData[CB_GLOBIE]));
  assign errSet = overrunEvt & errIe & globIe;
  assign unusedWrBits = ^wrData[DATA_W-1:CTRL_BITS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxEn     <= 1'b0;
      autoMode <= 1'b0;
      rxIe     <= 1'b0;
      errIe    <= 1'b0;
      globIe   <= 1'b0;
      bufFull  <= 1'b0;
      overrun  <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (ctrlWr) begin
        rxEn     <= wrData[CB_RXEN];
        autoMode <= wrData[CB_AUTO];
        rxIe     <= wrData[CB_RXIE];
        errIe    <= wrData[CB_ERRIE];
        globIe   <= wrData[CB_GLOBIE];
      end
      if (loadEvt)                              bufFull <= 1'b1;
      else if (statWr && !wrData[SB_FULL])      bufFull <= 1'b0;
      if (overrunEvt)                           overrun <= 1'b1;
      else if (statWr && !wrData[SB_OVR])       overrun <= 1'b0;
      if (errSet)                               errFlag <= 1'b1;
      else if (errClr)                          errFlag <= 1'b0;
    end
  end

  assign goRx   = rxEn & ~autoMode;
  assign rxIrq  = bufFull & rxIe & globIe;
  assign errIrq = errFlag & errIe & globIe;

  always_comb begin
    rdData = '0;
    case (regSel)
      SEL_CTRL: begin
        rdData[CB_RXEN]   = rxEn;
        rdData[CB_AUTO]   = autoMode;
        rdData[CB_RXIE]   = rxIe;
        rdData[CB_ERRIE]  = errIe;
        rdData[CB_GLOBIE] = globIe;
      end
      SEL_STAT: begin
        rdData[SB_FULL] = bufFull;
        rdData[SB_OVR]  = overrun;
        rdData[SB_ERR]  = errFlag;
      end
      SEL_DATA: rdData = rxBuf;
      default:  rdData = '0;
    endcase
  end

  // R3: a load always leaves the buffer marked full
  a_r3_full_after_load: assert property (@(posedge clk) disable iff (!rstN)
    loadEvt |=> bufFull);

  // R6: an overrun event is always recorded
  a_r6_overrun_flag: assert property (@(posedge clk) disable iff (!rstN)
    overrunEvt |=> overrun);

  // R7: error flag never outlives the overrun flag
  a_r7_err_needs_ovr: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> overrun);

  // R5: clearing the full flag works when no load competes
  a_r5_full_clear: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && !wrData[SB_FULL] && !loadEvt) |=> !bufFull);

endmodule

// File: rtl/clk_ser_rx.sv
module clk_ser_rx
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              serData,
  output logic              serClk,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rxIrq,
  output logic              errIrq
);
  rxStrobe_t         strb;
  logic              lastBit, firstBit;
  logic              loadEvt, overrunEvt;
  logic              goRx, bufFull;
  logic [DATA_W-1:0] rxBuf;

  rxs_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .goRx       (goRx),
    .bufFull    (bufFull),
    .lastBit    (lastBit),
    .firstBit   (firstBit),
    .strb       (strb),
    .loadEvt    (loadEvt),
    .overrunEvt (overrunEvt),
    .serClk     (serClk)
  );

  rxs_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .serData  (serData),
    .lastBit  (lastBit),
    .firstBit (firstBit),
    .rxBuf    (rxBuf)
  );

  rxs_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .regSel     (regSel),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .rdData     (rdData),
    .rxBuf      (rxBuf),
    .loadEvt    (loadEvt),
    .overrunEvt (overrunEvt),
    .goRx       (goRx),
    .bufFull    (bufFull),
    .rxIrq      (rxIrq),
    .errIrq     (errIrq)
  );

endmodule

// File: tb/clk_ser_rx_test.sv
`timescale 1ns/1ps
module clk_ser_rx_test;
  localparam int DW = 8;

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, serData = 1'b0, wrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic serClk, rxIrq, errIrq;

  always #2 clk = ~clk;

  clk_ser_rx #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .serData(serData), .serClk(serClk),
    .regSel(regSel), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .rxIrq(rxIrq), .errIrq(errIrq));

  int total = 0, bad = 0;
  int riseCnt = 0, fallCnt = 0;
  int r2Bad = 0, ticksSince = 0;
  bit finished = 0, countOn = 0;
  logic [7:0] txBytes [64];
  logic [7:0] expBuf = '0, ctrlVal = '0;
  bit expFull = 0, expOvr = 0, expErr = 0;

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // tick source: one tick every 2 to 4 clocks
  initial begin
    forever begin
      int gap;
      gap = $urandom_range(4, 2);
      repeat (gap - 1) begin @(negedge clk); tickEn = 1'b0; end
      @(negedge clk); tickEn = 1'b1;
    end
  end

  // sender: new bit on every falling serial edge, LSB first
  initial begin
    forever begin
      @(negedge serClk);
      if (countOn) begin
        serData = txBytes[(fallCnt / 8) % 64][fallCnt % 8];
        fallCnt++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge serClk);
      if (countOn) riseCnt++;
    end
  end

  // R2 monitor: changes only on ticks, one tick from fall to rise
  initial begin
    forever begin
      logic oldSer, t;
      @(posedge clk); oldSer = serClk; t = tickEn;
      @(negedge clk);
      if (countOn) begin
        if (t) ticksSince++;
        if (serClk !== oldSer) begin
          if (!t) r2Bad++;
          if (serClk === 1'b1 && ticksSince != 1) r2Bad++;
          ticksSince = 0;
        end
      end
    end
  end

  task automatic wrReg(input logic [1:0] sel, input logic [7:0] v);
    @(negedge clk); regSel = sel; wrData = v; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] sel, output logic [7:0] v);
    @(negedge clk); regSel = sel; #1 v = rdData;
  endtask

  task automatic cwr(input logic [7:0] v);
    wrReg(2'd0, v); ctrlVal = v;
    if (!(v[3] && v[4])) expErr = 0;
  endtask

  task automatic swr(input logic [7:0] v);
    wrReg(2'd1, v);
    if (!v[0]) expFull = 0;
    if (!v[1]) begin expOvr = 0; expErr = 0; end
    if (!v[2]) expErr = 0;
  endtask

  task automatic waitByte();
    int tgt;
    tgt = (riseCnt / 8 + 1) * 8;
    wait (riseCnt >= tgt);
    @(negedge clk);
    if (expFull) begin
      expOvr = 1;
      if (ctrlVal[3] && ctrlVal[4]) expErr = 1;
    end else begin
      expBuf = txBytes[(tgt / 8 - 1) % 64];
      expFull = 1;
    end
  endtask

  task automatic checkAll(input string req);
    logic [7:0] v;
    rdReg(2'd1, v); chk(req, "status", v, {5'd0, expErr, expOvr, expFull});
    rdReg(2'd2, v); chk(req, "buffer", v, expBuf);
    chk("R4", "rxIrq", rxIrq, expFull && ctrlVal[2] && ctrlVal[4]);
    chk("R7", "errIrq", errIrq, expErr && ctrlVal[3] && ctrlVal[4]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int mark;
    void'($urandom(32'h1234_5eed));
    for (int i = 0; i < 64; i++) txBytes[i] = 8'($urandom_range(255, 0));
    txBytes[0] = 8'hA5; txBytes[1] = 8'h3C;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    countOn = 1;

    // R9 reset state
    chk("R9", "serClk", serClk, 1);
    rdReg(2'd0, v); chk("R9", "ctrl", v, 0);
    rdReg(2'd1, v); chk("R9", "status", v, 0);
    rdReg(2'd2, v); chk("R9", "buffer", v, 0);
    chk("R9", "irqs", {rxIrq, errIrq}, 0);

    // R1 auto mode blocks reception
    cwr(8'h03);
    repeat (60) @(negedge clk);
    chk("R1", "serClk parked", serClk, 1);
    chk("R1", "no rises", riseCnt, 0);
    rdReg(2'd1, v); chk("R1", "status", v, 0);

    // R3/R4 first byte
    cwr(8'h1D);
    waitByte();
    checkAll("R3");
    chk("R3", "byte A5", expBuf, 8'hA5);

    // R6/R7 overrun with buffer unread
    waitByte();
    checkAll("R6");
    chk("R7", "errIrq raised", errIrq, 1);
    cwr(8'h15);
    checkAll("R7");
    cwr(8'h1D);
    chk("R7", "errIrq stays low", errIrq, 0);

    // R5 clear full only, overrun untouched by 1 bits
    swr(8'h06);
    checkAll("R5");
    swr(8'h05);
    checkAll("R5");
    waitByte();
    checkAll("R5");

    // random mix
    for (int i = 0; i < 24; i++) begin
      int act;
      act = $urandom_range(3, 0);
      case (act)
        0: swr(8'h06);
        1: swr(8'h05);
        2: cwr(8'h15 | ($urandom_range(1, 0) ? 8'h08 : 8'h00));
        default: ;
      endcase
      waitByte();
      checkAll("R6");
    end

    // R8 disable mid-byte
    swr(8'h00);
    mark = riseCnt + 3;
    wait (riseCnt >= mark);
    @(negedge clk);
    cwr(8'h1C);
    waitByte();
    checkAll("R8");
    mark = riseCnt;
    repeat (80) @(negedge clk);
    chk("R8", "clock parked", serClk, 1);
    chk("R8", "no more bits", riseCnt, mark);

    // R10 restart aligned to new byte
    swr(8'h00);
    cwr(8'h1D);
    waitByte();
    checkAll("R10");
    chk("R10", "byte index", expBuf, txBytes[(riseCnt / 8 - 1) % 64]);

    chk("R2", "clock timing violations", r2Bad, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule